// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects interrupt requests from many peripherals and produces one interrupt output per line. Each line is one of two kinds, fixed at build time by a constant mask. A direct line passes its input level to its output. A configurable line watches its input for a rising edge, a falling edge or both. When a selected edge arrives and the line is unmasked, it latches a pending flag and emits a one-cycle pulse on its output. Software can also fire a configurable line through a trigger register.

The default build has 40 lines, spread over two register banks. The lower bank covers lines 0 to 31 and the upper bank covers lines 32 to 39. Lines 26 to 31 are direct and serve serial-port interrupts. All other lines are configurable. Software reaches the per-bank registers through a simple read/write strobe port with a 10-bit byte address. Inputs must be synchronous to `clk`.

Top module: `xline_irq_ctrl`

## Requirements
- R1: After synchronous reset, every output is low and every register reads zero.
- R2: A direct line (default: lines 26–31) drives its output to its input level with one cycle of latency. It never sets a pending flag.
- R3: When a configurable line sees a 0→1 input change while its rising-select bit and its unmask bit are set, its pending bit is set. Its output is high for exactly the next cycle.
- R4: The same as R3 for a 1→0 change when the falling-select bit is set.
- R5: A configurable line does nothing in these cases: an edge of a kind that is not selected, no edge selected at all, or an input that stays high or stays low.
- R6: A cleared unmask bit stops a configurable line from setting its pending bit and from pulsing, for edges and for software triggers alike.
- R7: Writing 1 to a pending bit clears it and writing 0 leaves it alone. If a new event arrives in the same cycle as the clear, the event wins.
- R8: Writing 1 to a software-trigger bit of an unmasked configurable line sets its pending bit and pulses its output on the next cycle. The software-trigger register always reads zero.
- R9: The rising-select, falling-select and pending bits of direct lines read zero and ignore writes. Bits for lines that do not exist (above line 39 in bank 1) read zero.
- R10: The register map is bank base 0x00 (lines 0–31) and 0x20 (lines 32–39). Within a bank, the offsets are +0x00 unmask, +0x08 rising select, +0x0C falling select, +0x10 software trigger and +0x14 pending. All other offsets inside the 0x400 window read zero. Read data appears the cycle after `reg_re`.
- R11: Lines 32–39 behave as in R3–R8 when controlled through the bank-1 registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 10 | Byte address within the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_in | input | 40 | Per-line interrupt inputs |
| irq_out | output | 40 | Per-line interrupt outputs, registered |

## Verification
The bench builds the block with its defaults: 40 lines in 32-bit banks, and lines 26–31 direct. This leaves bank 1 only partly populated, so the absent bits 40–63 and the bank-1 register decode are both exercised. It also puts a group of direct lines inside a bank that otherwise holds configurable ones, so the masking of direct bits in the select and pending registers can be seen on reads. Random input toggling and random register traffic run against a cycle model in the bench, after directed cases for each kind of edge, the mask, write-1-to-clear and software trigger.

// File: rtl/xline_pkg.sv
package xline_pkg;
  // Byte address bits below this select the register within a bank
  localparam int XL_BANK_SHIFT = 5;

  typedef enum logic [4:0] {
    OFF_UNMASK = 5'h00,
    OFF_RISE   = 5'h08,
    OFF_FALL   = 5'h0C,
    OFF_SWTRIG = 5'h10,
    OFF_PEND   = 5'h14
  } xl_off_e;
endpackage

// File: rtl/xline_lane.sv
module xline_lane #(
  parameter bit DIRECT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic mask_en,
  input  logic rise_en,
  input  logic fall_en,
  input  logic sw_hit,
  output logic hit_o,
  output logic line_out
);
  logic prev_q;
  logic out_q;
  logic edge_hit;
  logic past_ok;

  always_comb begin
    edge_hit = mask_en & ((line_in & ~prev_q & rise_en) |
                          (~line_in & prev_q & fall_en) |
                          sw_hit);
    hit_o    = DIRECT ? 1'b0 : edge_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      out_q   <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      prev_q  <= line_in;
      out_q   <= DIRECT ? line_in : edge_hit;
      past_ok <= 1'b1;
    end
  end

  assign line_out = out_q;

  // R2: a direct output is the input of the previous cycle
  p_direct_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (DIRECT && past_ok) |-> (line_out == $past(line_in)));

  // R6: a configurable pulse requires the line to have been unmasked
  p_mask_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (!DIRECT && past_ok && line_out) |-> $past(mask_en));

  // R5: a configurable pulse requires an input change or a software trigger
  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!DIRECT && past_ok && line_out) |->
      (($past(line_in) != $past(prev_q)) || $past(sw_hit)));
endmodule

// File: rtl/xline_regs.sv
module xline_regs
  import xline_pkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 10,
  parameter logic [NUM_LINES-1:0] DIRECT_LINES = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic                 reg_re,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [BANK_W-1:0]    reg_wdata,
  output logic [BANK_W-1:0]    reg_rdata,
  input  logic [NUM_LINES-1:0] hit_vec,
  output logic [NUM_LINES-1:0] mask_vec,
  output logic [NUM_LINES-1:0] rise_vec,
  output logic [NUM_LINES-1:0] fall_vec,
  output logic [NUM_LINES-1:0] sw_vec
);
  localparam int NUM_BANKS = (NUM_LINES + BANK_W - 1) / BANK_W;
  localparam int PAD_W     = NUM_BANKS * BANK_W;
  localparam int BANK_AW   = ADDR_W - XL_BANK_SHIFT;
  localparam logic [PAD_W-1:0] LINE_OK = PAD_W'({NUM_LINES{1'b1}});
  localparam logic [PAD_W-1:0] CFG_OK  = LINE_OK & ~PAD_W'(DIRECT_LINES);

  logic [PAD_W-1:0] mask_q, rise_q, fall_q, pend_q;
  logic [BANK_AW-1:0] bank_idx;
  logic [XL_BANK_SHIFT-1:0] off;
  logic bank_ok;
  int sh;
  logic [PAD_W-1:0] lane_mask, wide_wd, hit_pad;
  logic [PAD_W-1:0] wm_mask, wm_rise, wm_fall, w1c_pad, rd_sel;
  logic [BANK_W-1:0] rd_next;
  logic past_ok;

  always_comb begin
    bank_idx  = reg_addr[ADDR_W-1:XL_BANK_SHIFT];
    off       = reg_addr[XL_BANK_SHIFT-1:0];
    bank_ok   = int'(bank_idx) < NUM_BANKS;
    sh        = bank_ok ? int'(bank_idx) * BANK_W : 0;
    lane_mask = bank_ok ? (PAD_W'({BANK_W{1'b1}}) << sh) : '0;
    wide_wd   = PAD_W'(reg_wdata) << sh;
    hit_pad   = PAD_W'(hit_vec);
    wm_mask   = (reg_we && off == OFF_UNMASK) ? lane_mask : '0;
    wm_rise   = (reg_we && off == OFF_RISE)   ? lane_mask : '0;
    wm_fall   = (reg_we && off == OFF_FALL)   ? lane_mask : '0;
    w1c_pad   = (reg_we && off == OFF_PEND)   ? (wide_wd & lane_mask) : '0;
    sw_vec    = (reg_we && off == OFF_SWTRIG) ?
                NUM_LINES'(wide_wd & lane_mask & CFG_OK) : '0;
    case (off)
      OFF_UNMASK: rd_sel = mask_q;
      OFF_RISE:   rd_sel = rise_q;
      OFF_FALL:   rd_sel = fall_q;
      OFF_PEND:   rd_sel = pend_q;
      default:    rd_sel = '0;
    endcase
    rd_next  = bank_ok ? BANK_W'(rd_sel >> sh) : '0;
    mask_vec = NUM_LINES'(mask_q);
    rise_vec = NUM_LINES'(rise_q);
    fall_vec = NUM_LINES'(fall_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      rise_q    <= '0;
      fall_q    <= '0;
      pend_q    <= '0;
      reg_rdata <= '0;
      past_ok   <= 1'b0;
    end else begin
      mask_q  <= (mask_q & ~wm_mask) | (wide_wd & wm_mask & LINE_OK);
      rise_q  <= (rise_q & ~wm_rise) | (wide_wd & wm_rise & CFG_OK);
      fall_q  <= (fall_q & ~wm_fall) | (wide_wd & wm_fall & CFG_OK);
      pend_q  <= ((pend_q & ~w1c_pad) | hit_pad) & CFG_OK;
      past_ok <= 1'b1;
      if (reg_re) reg_rdata <= rd_next;
    end
  end

  // R3: a pending bit only rises when its lane reported an event
  p_pend_source_r3: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((pend_q & ~$past(pend_q) & ~$past(hit_pad)) == '0));

  // R7: a write-1 clear without a concurrent event leaves the bit low
  p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((pend_q & $past(w1c_pad) & ~$past(hit_pad)) == '0));
endmodule

// File: rtl/xline_irq_ctrl.sv
module xline_irq_ctrl #(
  parameter int NUM_LINES = 40,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 10,
  parameter logic [NUM_LINES-1:0] DIRECT_LINES = 40'h00_FC00_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic                 reg_re,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [BANK_W-1:0]    reg_wdata,
  output logic [BANK_W-1:0]    reg_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_out
);
  logic [NUM_LINES-1:0] hit_vec, mask_vec, rise_vec, fall_vec, sw_vec;

  xline_regs #(
    .NUM_LINES(NUM_LINES), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
    .DIRECT_LINES(DIRECT_LINES)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hit_vec(hit_vec), .mask_vec(mask_vec), .rise_vec(rise_vec),
    .fall_vec(fall_vec), .sw_vec(sw_vec)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
    xline_lane #(.DIRECT(DIRECT_LINES[i])) u_lane (
      .clk(clk), .rst(rst),
      .line_in(irq_in[i]), .mask_en(mask_vec[i]),
      .rise_en(rise_vec[i]), .fall_en(fall_vec[i]),
      .sw_hit(sw_vec[i]), .hit_o(hit_vec[i]), .line_out(irq_out[i])
    );
  end
endmodule

// File: tb/xline_irq_ctrl_test.sv
`timescale 1ns/100ps
module xline_irq_ctrl_test;
  localparam int NL = 40;
  localparam logic [63:0] DIR   = 64'h0000_0000_FC00_0000;
  localparam logic [63:0] EXIST = 64'h0000_00FF_FFFF_FFFF;
  localparam logic [63:0] CFG   = EXIST & ~DIR;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [9:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NL-1:0] irq_in = '0;
  logic [NL-1:0] irq_out;

  int total = 0;
  int bad = 0;

  // model state
  logic [63:0] m_mask = '0, m_rise = '0, m_fall = '0, m_pend = '0, m_prev = '0;
  logic [NL-1:0] cur_in = '0;

  always #2.5 clk = ~clk;

  xline_irq_ctrl uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  function automatic logic [31:0] mread(logic [9:0] a);
    int b = int'(a[9:5]);
    logic [63:0] t;
    if (b >= 2) return 32'h0;
    case (a[4:0])
      5'h00: t = m_mask;
      5'h08: t = m_rise;
      5'h0C: t = m_fall;
      5'h14: t = m_pend;
      default: t = '0;
    endcase
    t = t >> (b * 32);
    return t[31:0];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock cycle: drive at negedge, model the edge, check at next negedge
  task automatic cyc(input logic [NL-1:0] lin, input logic we, input logic re,
                     input logic [9:0] a, input logic [31:0] d, input string tag);
    logic [63:0] in64, sw, w1c, hit, exp_out, wv, bm;
    logic [31:0] exp_rd;
    int b;
    reg_we = we; reg_re = re; reg_addr = a; reg_wdata = d; irq_in = lin;
    in64 = 64'(lin);
    b = int'(a[9:5]);
    wv = '0; bm = '0;
    if (b < 2) begin
      wv = 64'(d) << (b * 32);
      bm = 64'hFFFF_FFFF << (b * 32);
    end
    sw  = (we && a[4:0] == 5'h10) ? (wv & bm & CFG) : '0;
    w1c = (we && a[4:0] == 5'h14) ? (wv & bm) : '0;
    hit = CFG & m_mask & ((in64 & ~m_prev & m_rise) | (~in64 & m_prev & m_fall) | sw);
    exp_out = (in64 & DIR) | hit;
    exp_rd = mread(a);
    m_pend = ((m_pend & ~w1c) | hit) & CFG;
    if (we && a[4:0] == 5'h00) m_mask = (m_mask & ~bm) | (wv & bm & EXIST);
    if (we && a[4:0] == 5'h08) m_rise = (m_rise & ~bm) | (wv & bm & CFG);
    if (we && a[4:0] == 5'h0C) m_fall = (m_fall & ~bm) | (wv & bm & CFG);
    m_prev = in64;
    cur_in = lin;
    @(negedge clk);
    check(tag, 64'(irq_out), exp_out[63:0] & EXIST);
    if (re) check(tag, 64'(reg_rdata), 64'(exp_rd));
    reg_we = 1'b0; reg_re = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input string tag);
    cyc(cur_in, 1'b1, 1'b0, a, d, tag);
  endtask
  task automatic rd(input logic [9:0] a, input string tag);
    cyc(cur_in, 1'b0, 1'b1, a, 32'h0, tag);
  endtask
  task automatic idle(input logic [NL-1:0] lin, input string tag);
    cyc(lin, 1'b0, 1'b0, 10'h0, 32'h0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [NL-1:0] v;
    logic [9:0] regs [10];
    void'($urandom(32'd7177));
    regs = '{10'h00, 10'h08, 10'h0C, 10'h10, 10'h14,
             10'h20, 10'h28, 10'h2C, 10'h30, 10'h34};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state of every register and of the outputs
    for (int k = 0; k < 10; k++) rd(regs[k], "R1");
    // R9: direct-line select bits do not stick
    wr(10'h08, 32'hFFFF_FFFF, "R9");
    rd(10'h08, "R9");
    wr(10'h00, 32'hFFFF_FFFF, "R6");
    wr(10'h0C, 32'h0000_0010, "R4");
    // R3: rising edge on line 3, then held high (R5)
    v = '0; v[3] = 1'b1;
    idle(v, "R3");
    idle(v, "R5"); idle(v, "R5"); idle(v, "R5");
    rd(10'h14, "R3");
    // R7: write 0 keeps, write 1 clears
    wr(10'h14, 32'h0, "R7"); rd(10'h14, "R7");
    wr(10'h14, 32'h8, "R7"); rd(10'h14, "R7");
    // R5: falling edge on a rise-only line
    v[3] = 1'b0; idle(v, "R5"); rd(10'h14, "R5");
    // R4: both edges on line 4
    v[4] = 1'b1; idle(v, "R4"); v[4] = 1'b0; idle(v, "R4"); rd(10'h14, "R4");
    // R5: no edge selected on line 2
    wr(10'h08, 32'hFFFF_FFFB, "R5");
    v[2] = 1'b1; idle(v, "R5"); v[2] = 1'b0; idle(v, "R5");
    // R6: masked line 5 and masked software trigger
    wr(10'h00, 32'hFFFF_FFDF, "R6");
    v[5] = 1'b1; idle(v, "R6"); v[5] = 1'b0; idle(v, "R6");
    wr(10'h10, 32'h0000_0020, "R6"); rd(10'h14, "R6");
    // R8: software trigger on line 7, register reads zero
    wr(10'h10, 32'h0000_0080, "R8"); idle(v, "R8");
    rd(10'h10, "R8"); rd(10'h14, "R8");
    // R7: clear concurrent with a new edge on line 9
    wr(10'h10, 32'h0000_0200, "R7");
    v[9] = 1'b1; cyc(v, 1'b1, 1'b0, 10'h14, 32'h0000_0200, "R7");
    rd(10'h14, "R7");
    // R2: direct line 27 follows level
    v[27] = 1'b1; idle(v, "R2"); idle(v, "R2"); idle(v, "R2");
    v[27] = 1'b0; idle(v, "R2"); rd(10'h14, "R2");
    wr(10'h14, 32'hFFFF_FFFF, "R7");
    // R11: bank 1, line 35
    wr(10'h20, 32'h0000_00FF, "R11");
    wr(10'h28, 32'h0000_0008, "R11");
    v[35] = 1'b1; idle(v, "R11"); idle(v, "R11");
    rd(10'h34, "R11");
    wr(10'h30, 32'h0000_0040, "R11"); rd(10'h34, "R11");
    // R9: absent lines in bank 1
    wr(10'h2C, 32'hFFFF_FFFF, "R9"); rd(10'h2C, "R9");
    wr(10'h20, 32'hFFFF_FFFF, "R9"); rd(10'h20, "R9");
    // R10: unused offsets and banks
    rd(10'h04, "R10"); rd(10'h18, "R10"); rd(10'h3FC, "R10"); rd(10'h40, "R10");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] flip;
      logic [9:0] a;
      int sel;
      flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      v = v ^ flip[NL-1:0];
      sel = int'($urandom % 10);
      a = ($urandom % 8 == 0) ? 10'($urandom) : regs[sel];
      case ($urandom % 4)
        0: cyc(v, 1'b1, 1'b0, a, $urandom, "R3");
        1: cyc(v, 1'b0, 1'b1, a, 32'h0, "R10");
        default: cyc(v, 1'b0, 1'b0, 10'h0, 32'h0, "R5");
      endcase
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule